// File: doc/BRIEF.md
# Interrupt controller programming decoder

This block is the byte-wide register interface of an eight-input interrupt controller. It sits between a simple synchronous strobe bus and the priority resolver core. It turns writes on a one-bit address into the start-up word sequence and the run-time commands. It holds the mask, the rotating priority offset and the mode bits, and it drives one-cycle clear pulses for the core's in-service and request registers.

Reads return the core's request or in-service register, or the mask. A poll read instead returns the level the resolver currently selects and acknowledges it. The core's request and in-service registers, and its chosen pending level, come in as inputs. All outputs are registered, so a write or read at a rising edge shows its effect in the following cycle.

Top module: `intc_cmd_dec`

## Requirements
- R1: After reset, mask_o, offset_o, vbase_o, rdata_o, nested_o, aeoi_o, rot_aeoi_o and smask_o are all zero, and no clear pulse is active.
- R2: A write to address 0 with data bit 4 set starts initialization. It zeroes mask_o, offset_o and smask_o, and it zeroes the read select. It pulses edge_clr_o for one cycle and records data bit 0 as "mode word expected". When bit 0 is clear, nested_o and aeoi_o are also zeroed. When bit 0 is set, they keep their values.
- R3: After initialization starts, the first address-1 write sets vbase_o to data bits 7:3. The second address-1 write changes nothing. A third address-1 write occurs only when the mode word is expected: it sets nested_o from data bit 4 and aeoi_o from data bit 1. Address-1 writes after that load the mask again.
- R4: Outside initialization, an address-1 write loads mask_o with the data byte.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a one-shot poll. Bit 1 set loads the read select from bit 0. Bit 6 set loads smask_o from bit 5, and bit 6 clear leaves smask_o unchanged.
- R6: Without poll, a read of address 0 returns isr_i when the read select is 1 and irr_i when it is 0. A read of address 1 returns mask_o.
- R7: For a write to address 0 with bits 4:3 equal to 00, bits 7:5 form a command code. Codes 0 and 4 set rot_aeoi_o to data bit 7. Code 2 changes nothing.
- R8: Code 1 pulses isr_clr_o at the set isr_i bit with the highest priority. The search starts at level offset_o and goes upward, wrapping from 7 to 0. Code 5 does the same and also sets offset_o to that level + 1, modulo 8.
- R9: Code 3 pulses isr_clr_o at the level given by bits 2:0. Code 7 does the same and also sets offset_o to that level + 1. Code 6 only sets offset_o to bits 2:0 + 1.
- R10: Code 1 or code 5 issued while isr_i is zero produces no pulse and leaves offset_o unchanged.
- R11: A read with poll armed disarms the poll. If pend_vld_i is high, it returns {5'b0, pend_lvl_i} and pulses both irr_clr_o and isr_clr_o at that level. Otherwise it returns 8'h07 and produces no pulse.
- R12: Every clear pulse (isr_clr_o, irr_clr_o, edge_clr_o) lasts exactly one cycle unless a new command triggers it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the core |
| isr_i | input | 8 | In-service register from the core |
| pend_vld_i | input | 1 | Core has a level to deliver |
| pend_lvl_i | input | 3 | Level the core would deliver |
| rdata_o | output | 8 | Read data, valid from the cycle after the read |
| mask_o | output | 8 | Mask register |
| offset_o | output | 3 | Priority rotation offset (lowest-numbered winner) |
| vbase_o | output | 5 | Vector base, upper five bits |
| nested_o | output | 1 | Fully nested mode |
| aeoi_o | output | 1 | Automatic end of interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end of interrupt |
| smask_o | output | 1 | Special mask mode |
| isr_clr_o | output | 8 | One-hot in-service clear pulse |
| irr_clr_o | output | 8 | One-hot request clear pulse (poll) |
| edge_clr_o | output | 1 | Clear edge memory pulse |

## Verification
Most decoder faults appear at the ports one cycle after the write that triggers them. Examples are a wrong rotation search, a clear pulse at the wrong level, or an offset left stale after a rotating end-of-interrupt. A fault in the start-up step counter shows up later, and only indirectly. A data write then lands in the mask instead of the vector base or the mode bits, or the reverse. For that reason the sequences run both with and without the mode word. The read select and poll flag have no port of their own. They are observed through the data returned by the next read.

// File: rtl/intc_cmd_dec.sv
module intc_cmd_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] irr_i,
  input  logic [7:0] isr_i,
  input  logic       pend_vld_i,
  input  logic [2:0] pend_lvl_i,
  output logic [7:0] rdata_o,
  output logic [7:0] mask_o,
  output logic [2:0] offset_o,
  output logic [4:0] vbase_o,
  output logic       nested_o,
  output logic       aeoi_o,
  output logic       rot_aeoi_o,
  output logic       smask_o,
  output logic [7:0] isr_clr_o,
  output logic [7:0] irr_clr_o,
  output logic       edge_clr_o
);

  typedef enum logic [1:0] {S_RUN, S_BASE, S_SKIP, S_MODE} ist_t;

  ist_t ist_q;
  logic need4_q, rsel_q, poll_q;

  wire       wr_cmd  = wr_i & ~addr_i;
  wire       wr_dat  = wr_i &  addr_i;
  wire       is_init = wr_cmd &  wdata_i[4];
  wire       is_mode = wr_cmd & ~wdata_i[4] &  wdata_i[3];
  wire       is_op   = wr_cmd & ~wdata_i[4] & ~wdata_i[3];
  wire [2:0] code    = wdata_i[7:5];
  wire [2:0] sel     = wdata_i[2:0];

  logic       hi_vld;
  logic [2:0] hi_lvl;

  always_comb begin
    hi_vld = 1'b0;
    hi_lvl = 3'd0;
    for (int p = 7; p >= 0; p--) begin
      if (isr_i[3'(offset_o + 3'(p))]) begin
        hi_vld = 1'b1;
        hi_lvl = 3'(offset_o + 3'(p));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q      <= S_RUN;
      need4_q    <= 1'b0;
      rsel_q     <= 1'b0;
      poll_q     <= 1'b0;
      rdata_o    <= 8'h00;
      mask_o     <= 8'h00;
      offset_o   <= 3'd0;
      vbase_o    <= 5'd0;
      nested_o   <= 1'b0;
      aeoi_o     <= 1'b0;
      rot_aeoi_o <= 1'b0;
      smask_o    <= 1'b0;
      isr_clr_o  <= 8'h00;
      irr_clr_o  <= 8'h00;
      edge_clr_o <= 1'b0;
    end else begin
      isr_clr_o  <= 8'h00;
      irr_clr_o  <= 8'h00;
      edge_clr_o <= 1'b0;

      if (is_init) begin
        ist_q      <= S_BASE;
        need4_q    <= wdata_i[0];
        mask_o     <= 8'h00;
        offset_o   <= 3'd0;
        smask_o    <= 1'b0;
        rsel_q     <= 1'b0;
        edge_clr_o <= 1'b1;
        if (!wdata_i[0]) begin
          nested_o <= 1'b0;
          aeoi_o   <= 1'b0;
        end
      end else if (is_mode) begin
        if (wdata_i[2]) poll_q  <= 1'b1;
        if (wdata_i[1]) rsel_q  <= wdata_i[0];
        if (wdata_i[6]) smask_o <= wdata_i[5];
      end else if (is_op) begin
        case (code)
          3'd0, 3'd4: rot_aeoi_o <= code[2];
          3'd1, 3'd5: if (hi_vld) begin
            isr_clr_o <= 8'd1 << hi_lvl;
            if (code[2]) offset_o <= 3'(hi_lvl + 3'd1);
          end
          3'd3: isr_clr_o <= 8'd1 << sel;
          3'd6: offset_o  <= 3'(sel + 3'd1);
          3'd7: begin
            isr_clr_o <= 8'd1 << sel;
            offset_o  <= 3'(sel + 3'd1);
          end
          default: ;
        endcase
      end else if (wr_dat) begin
        case (ist_q)
          S_RUN:  mask_o <= wdata_i;
          S_BASE: begin
            vbase_o <= wdata_i[7:3];
            ist_q   <= S_SKIP;
          end
          S_SKIP: ist_q <= need4_q ? S_MODE : S_RUN;
          S_MODE: begin
            nested_o <= wdata_i[4];
            aeoi_o   <= wdata_i[1];
            ist_q    <= S_RUN;
          end
          default: ist_q <= S_RUN;
        endcase
      end

      if (rd_i) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (pend_vld_i) begin
            rdata_o   <= {5'd0, pend_lvl_i};
            irr_clr_o <= 8'd1 << pend_lvl_i;
            isr_clr_o <= 8'd1 << pend_lvl_i;
          end else begin
            rdata_o <= 8'h07;
          end
        end else begin
          rdata_o <= addr_i ? mask_o : (rsel_q ? isr_i : irr_i);
        end
      end
    end
  end

endmodule

// File: rtl/intc_cmd_chk.sv
module intc_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_i,
  input logic       rd_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] isr_i,
  input logic [7:0] mask_o,
  input logic [2:0] offset_o,
  input logic       nested_o,
  input logic       aeoi_o,
  input logic       smask_o,
  input logic [7:0] isr_clr_o,
  input logic [7:0] irr_clr_o,
  input logic       edge_clr_o
);

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4]) |=>
      (mask_o == 8'h00 && offset_o == 3'd0 && !smask_o && edge_clr_o));

  p_init_modes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4] && !wdata_i[0]) |=> (!nested_o && !aeoi_o));

  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr_o));

  p_spec_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b01100 && !rd_i) |=>
      (isr_clr_o == (8'd1 << $past(wdata_i[2:0]))));

  p_eoi_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[6:5] == 2'b01 &&
     isr_i == 8'h00 && !rd_i) |=> (isr_clr_o == 8'h00 && $stable(offset_o)));

  p_poll_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_clr_o != 8'h00) |-> (irr_clr_o == isr_clr_o && $onehot(irr_clr_o)));

  p_edge_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_clr_o && !(wr_i && !addr_i && wdata_i[4])) |=> !edge_clr_o);

endmodule

bind intc_cmd_dec intc_cmd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .isr_i(isr_i), .mask_o(mask_o), .offset_o(offset_o),
  .nested_o(nested_o), .aeoi_o(aeoi_o), .smask_o(smask_o),
  .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o), .edge_clr_o(edge_clr_o)
);

// File: tb/test_intc_cmd_dec.sv
module test_intc_cmd_dec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00, irr_i = 8'h00, isr_i = 8'h00;
  logic pend_vld_i = 1'b0;
  logic [2:0] pend_lvl_i = 3'd0;
  logic [7:0] rdata_o, mask_o, isr_clr_o, irr_clr_o;
  logic [2:0] offset_o;
  logic [4:0] vbase_o;
  logic nested_o, aeoi_o, rot_aeoi_o, smask_o, edge_clr_o;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  intc_cmd_dec i_intc_cmd_dec (.*);

  // {rd, addr, data, irr, isr, exp_rdata, exp_mask, exp_offset}
  localparam int NV = 9;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hA5, 3'd0},
    {1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hA5, 3'd0},
    {1'b1, 1'b0, 8'h00, 8'h3C, 8'h00, 8'h3C, 8'hA5, 3'd0},
    {1'b0, 1'b0, 8'h0B, 8'h00, 8'h00, 8'h00, 8'hA5, 3'd0},
    {1'b1, 1'b0, 8'h00, 8'h00, 8'h81, 8'h81, 8'hA5, 3'd0},
    {1'b0, 1'b0, 8'hC3, 8'h00, 8'h00, 8'h00, 8'hA5, 3'd4},
    {1'b0, 1'b0, 8'h0A, 8'h00, 8'h00, 8'h00, 8'hA5, 3'd4},
    {1'b1, 1'b0, 8'h00, 8'h11, 8'h00, 8'h11, 8'hA5, 3'd4},
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mask", mask_o, 0);
    chk("R1 offset", offset_o, 0);
    chk("R1 modes", {nested_o, aeoi_o, rot_aeoi_o, smask_o, vbase_o, rdata_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 no pulse after reset", {isr_clr_o, irr_clr_o, edge_clr_o}, 0);

    for (int i = 0; i < NV; i++) begin
      irr_i = VEC[i][34:27];
      isr_i = VEC[i][26:19];
      if (VEC[i][44]) rd(VEC[i][43]); else wr(VEC[i][43], VEC[i][42:35]);
      if (VEC[i][44]) chk($sformatf("R6 table %0d rdata", i), rdata_o, VEC[i][18:11]);
      chk($sformatf("R4 R5 table %0d mask", i), mask_o, VEC[i][10:3]);
      chk($sformatf("R9 table %0d offset", i), offset_o, VEC[i][2:0]);
    end
    irr_i = 8'h00; isr_i = 8'h00;

    // init with mode word
    wr(1'b0, 8'h11);
    chk("R2 edge pulse", edge_clr_o, 1);
    chk("R2 clears", {mask_o, offset_o}, 0);
    @(negedge clk);
    chk("R12 edge pulse one cycle", edge_clr_o, 0);
    wr(1'b1, 8'h48);
    chk("R3 vector base", vbase_o, 5'd9);
    wr(1'b1, 8'h77);
    chk("R3 second word ignored", mask_o, 0);
    wr(1'b1, 8'h12);
    chk("R3 mode word", {nested_o, aeoi_o}, 2'b11);
    chk("R3 mode word not mask", mask_o, 0);
    wr(1'b1, 8'h33);
    chk("R4 mask after init", mask_o, 8'h33);

    // init with mode word expected keeps modes
    wr(1'b0, 8'h11);
    chk("R2 modes kept", {nested_o, aeoi_o}, 2'b11);
    wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    chk("R3 fourth word clears modes", {nested_o, aeoi_o}, 2'b00);

    // init without mode word
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h12);
    wr(1'b0, 8'h10);
    chk("R2 modes cleared", {nested_o, aeoi_o}, 2'b00);
    wr(1'b1, 8'h20);
    chk("R3 base no fourth", vbase_o, 5'd4);
    wr(1'b1, 8'hFF);
    chk("R3 skip word", mask_o, 0);
    wr(1'b1, 8'h5A);
    chk("R3 back to mask", mask_o, 8'h5A);
    chk("R3 modes untouched", {nested_o, aeoi_o}, 2'b00);

    // special mask
    wr(1'b0, 8'h68);
    chk("R5 smask set", smask_o, 1);
    wr(1'b0, 8'h28);
    chk("R5 smask held", smask_o, 1);
    wr(1'b0, 8'h48);
    chk("R5 smask cleared", smask_o, 0);

    // rotate-on-auto flag, code 2
    wr(1'b0, 8'h80);
    chk("R7 rot set", rot_aeoi_o, 1);
    isr_i = 8'hFF;
    wr(1'b0, 8'h47);
    chk("R7 code2 no pulse", isr_clr_o, 0);
    chk("R7 code2 state", {rot_aeoi_o, offset_o}, {1'b1, 3'd0});
    wr(1'b0, 8'h00);
    chk("R7 rot clear", rot_aeoi_o, 0);

    // non-specific EOI with rotation search
    wr(1'b0, 8'hC4);
    chk("R9 code6 offset", offset_o, 3'd5);
    isr_i = 8'b0000_1001;
    wr(1'b0, 8'h20);
    chk("R8 wrapped search", isr_clr_o, 8'h01);
    chk("R8 code1 offset kept", offset_o, 3'd5);
    @(negedge clk);
    chk("R12 isr pulse one cycle", isr_clr_o, 0);
    isr_i = 8'h08;
    wr(1'b0, 8'hA0);
    chk("R8 code5 clear", isr_clr_o, 8'h08);
    chk("R8 code5 offset", offset_o, 3'd4);
    isr_i = 8'h00;
    wr(1'b0, 8'hA0);
    chk("R10 empty eoi", {isr_clr_o, offset_o}, {8'h00, 3'd4});
    wr(1'b0, 8'h20);
    chk("R10 empty eoi code1", isr_clr_o, 0);

    // specific EOI
    wr(1'b0, 8'h66);
    chk("R9 code3 clear", isr_clr_o, 8'h40);
    chk("R9 code3 offset", offset_o, 3'd4);
    wr(1'b0, 8'hE7);
    chk("R9 code7 clear", isr_clr_o, 8'h80);
    chk("R9 code7 offset wrap", offset_o, 3'd0);

    // poll
    pend_vld_i = 1'b1; pend_lvl_i = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R11 poll data", rdata_o, 8'h05);
    chk("R11 poll clears", {irr_clr_o, isr_clr_o}, {8'h20, 8'h20});
    rd(1'b1);
    chk("R11 poll disarmed", rdata_o, 8'h5A);
    chk("R12 poll pulse gone", irr_clr_o, 0);
    pend_vld_i = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R11 empty poll", rdata_o, 8'h07);
    chk("R11 empty poll no pulse", {irr_clr_o, isr_clr_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule